// File: doc/BRIEF.md
# Retriggerable Programmable Gate Generator

This block makes one gate pulse whose length is a programmed number of timer steps. A timer clock that only runs once a start request arrives is modelled as a half-tick strobe, `tick_en`, on the system clock: each strobe marks one edge of the timer clock. Successive strobes alternate between a rising and a falling edge, and the first strobe after a trigger is a rising edge. In single-edge mode a step is one full timer period, which is two strobes. In dual-edge mode a step is one strobe, which halves the resolution.

A trigger is a falling edge on the active-low `start_n`. Two internal timer channels take triggers in turn. When a trigger lands while a gate is already running, it starts a channel that is idle, and the one gate stays high until every running channel has finished its own count. The block needs no recovery gap, so a new gate may start on the clock right after the previous one ends.

Top module: `retrig_gate_gen`

## Requirements
- R1: In single-edge mode (`dual_edge`=0) the gate rises after the first `tick_en` edge that follows the clock edge accepting a trigger. It stays high for N steps of two strobes each and falls on the strobe that completes step N. With a strobe every 2 clocks, the gate is high for 4·N clocks.
- R2: In dual-edge mode (`dual_edge`=1) every strobe is one step, so with a strobe every 2 clocks the gate is high for 2·N clocks.
- R3: `width` is an unsigned binary step count N. It is captured when the trigger is accepted, and a later change does not alter the running gate.
- R4: A `width` of 0 behaves as N=1, so every trigger produces a non-empty gate.
- R5: A trigger is a high-to-low transition of `start_n`. Holding `start_n` low counts as one trigger only, and no further gate follows while it stays low.
- R6: No recovery time is needed. A falling edge of `start_n` on the clock right after a gate ends is accepted, and `busy` is high from the edge that accepts it.
- R7: A trigger that arrives while one channel is counting starts the idle channel. The gate stays continuously high until the later channel completes its N steps, counted from its own trigger.
- R8: A trigger that arrives while both channels are counting restarts the channel that was triggered earlier. The gate then ends N steps after that newest trigger.
- R9: `busy` is high whenever any channel is counting, and the gate is never high without `busy`.
- R10: A synchronous reset (`rst`=1 at a clock edge) clears both channels, so `gate` and `busy` are 0 after that edge and stay 0 until the next trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_n | input | 1 | Active-low start request; each falling edge is a trigger |
| width | input | CW | Gate length in steps (0 behaves as 1) |
| dual_edge | input | 1 | 1: count both timer edges (half-step); 0: rising edges only |
| tick_en | input | 1 | Half-tick strobe, one per timer-clock edge |
| gate | output | 1 | Gate output |
| busy | output | 1 | High while any channel is counting |

## Verification
A wrong count, target or phase inside a channel appears directly as a gate length that is off by whole steps or half-steps. That error becomes visible on the clock where the gate falls, at most N steps after the trigger. A steering fault, such as arming a busy channel or losing the age order, shortens merged gates or splits them into several pulses, and this is visible within one gate length of the overlapping trigger. A broken edge detector or reset shows up within a few clocks as spurious gates while `start_n` is held low, or as `busy` staying high after reset.

// File: rtl/gg_pkg.sv
package gg_pkg;
   localparam int GG_CHANNELS = 2;
   typedef logic [GG_CHANNELS-1:0] ch_vec_t;
endpackage

// File: rtl/gg_start_detect.sv
module gg_start_detect (
   input  logic clk,
   input  logic rst,
   input  logic start_n,
   output logic trig
);
   logic start_q;

   always_ff @(posedge clk) begin
      if (rst) start_q <= 1'b1;
      else     start_q <= start_n;
   end

   assign trig = start_q & ~start_n & ~rst;

   AST_SINGLE_TRIGGER: assert property (@(posedge clk) disable iff (rst)
      trig |=> !trig) else $error("two triggers in a row"); // R5
endmodule

// File: rtl/gg_tick_channel.sv
module gg_tick_channel #(
   parameter int CW           = 8,
   parameter bit DUAL_EDGE_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          arm,
   input  logic [CW-1:0] width,
   input  logic          tick_en,
   input  logic          dual,
   output logic          active,
   output logic          lit
);
   localparam logic [CW-1:0] ONE_STEP = CW'(1);

   if (CW < 2) begin : g_bad_cw
      $error("gg_tick_channel: CW must be at least 2");
   end

   logic          run;
   logic          phase;
   logic [CW-1:0] cnt;
   logic [CW-1:0] tgt;
   logic          step_ev;

   if (DUAL_EDGE_EN) begin : g_dual
      assign step_ev = run & tick_en & (dual | ~phase);
   end else begin : g_single
      assign step_ev = run & tick_en & ~phase;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         run   <= 1'b0;
         phase <= 1'b0;
         cnt   <= '0;
         tgt   <= ONE_STEP;
      end else if (arm) begin
         run   <= 1'b1;
         phase <= 1'b0;
         cnt   <= '0;
         tgt   <= (width == '0) ? ONE_STEP : width;
      end else if (run && tick_en) begin
         phase <= ~phase;
         if (step_ev) begin
            if (cnt == tgt) run <= 1'b0;
            else            cnt <= cnt + ONE_STEP;
         end
      end
   end

   assign active = run;
   assign lit    = run & (cnt != '0);

   AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
      run |-> (cnt <= tgt)) else $error("count past target"); // R1
   AST_TARGET_NONZERO: assert property (@(posedge clk) disable iff (rst)
      run |-> (tgt != '0)) else $error("empty target"); // R4
endmodule

// File: rtl/gg_steer.sv
module gg_steer
   import gg_pkg::*;
(
   input  logic    clk,
   input  logic    rst,
   input  logic    trig,
   input  ch_vec_t act,
   output ch_vec_t arm
);
   logic last;
   logic sel;

   always_comb begin
      if (!act[0] && !act[1]) sel = ~last;
      else if (!act[0])       sel = 1'b0;
      else if (!act[1])       sel = 1'b1;
      else                    sel = ~last;
      arm = '0;
      if (trig) arm[sel] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst)       last <= 1'b1;
      else if (trig) last <= sel;
   end

   AST_ARM_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(arm)) else $error("two channels armed"); // R7
   AST_ARM_ON_TRIGGER: assert property (@(posedge clk) disable iff (rst)
      trig |-> ($countones(arm) == 1)) else $error("trigger lost"); // R8
endmodule

// File: rtl/retrig_gate_gen.sv
module retrig_gate_gen
   import gg_pkg::*;
#(
   parameter int CW           = 8,
   parameter bit DUAL_EDGE_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start_n,
   input  logic [CW-1:0] width,
   input  logic          dual_edge,
   input  logic          tick_en,
   output logic          gate,
   output logic          busy
);
   logic    trig;
   ch_vec_t arm;
   ch_vec_t act;
   ch_vec_t lit;
   logic    gate_q;

   gg_start_detect u_start (
      .clk     (clk),
      .rst     (rst),
      .start_n (start_n),
      .trig    (trig)
   );

   gg_steer u_steer (
      .clk  (clk),
      .rst  (rst),
      .trig (trig),
      .act  (act),
      .arm  (arm)
   );

   for (genvar i = 0; i < GG_CHANNELS; i++) begin : g_ch
      gg_tick_channel #(
         .CW           (CW),
         .DUAL_EDGE_EN (DUAL_EDGE_EN)
      ) u_ch (
         .clk     (clk),
         .rst     (rst),
         .arm     (arm[i]),
         .width   (width),
         .tick_en (tick_en),
         .dual    (dual_edge),
         .active  (act[i]),
         .lit     (lit[i])
      );
   end

   assign gate = (|lit) | (gate_q & (|act));
   assign busy = |act;

   always_ff @(posedge clk) begin
      if (rst) gate_q <= 1'b0;
      else     gate_q <= gate;
   end

   AST_GATE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
      gate |-> busy) else $error("gate without busy"); // R9
   AST_GATE_ENDS_IDLE: assert property (@(posedge clk) disable iff (rst)
      $fell(gate) |-> !busy) else $error("gate split while busy"); // R7
   AST_BUSY_AFTER_TRIG: assert property (@(posedge clk) disable iff (rst)
      trig |=> busy) else $error("trigger not accepted"); // R6
endmodule

// File: tb/sim_retrig_gate_gen.sv
module sim_retrig_gate_gen;
   localparam int CLK_PERIOD = 10;
   localparam int CW         = 5;
   localparam int STEP_S     = 4;
   localparam int STEP_D     = 2;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          start_n = 1'b1;
   logic          dual = 1'b0;
   logic [CW-1:0] width = '0;
   logic [7:0]    tcnt = '0;
   logic          tick_en;
   logic          gate;
   logic          busy;
   int            checks = 0;
   int            fails = 0;

   assign tick_en = tcnt[0];

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) tcnt <= tcnt + 8'd1;

   retrig_gate_gen #(.CW(CW)) u0 (
      .clk(clk), .rst(rst), .start_n(start_n), .width(width),
      .dual_edge(dual), .tick_en(tick_en), .gate(gate), .busy(busy)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic align();
      @(negedge clk);
      while (tick_en) @(negedge clk);
   endtask

   task automatic pulse();
      start_n = 1'b0;
      @(negedge clk);
      start_n = 1'b1;
   endtask

   task automatic measure(output int len);
      int guard = 0;
      len = 0;
      while (!busy && guard < 50) begin
         @(negedge clk);
         guard++;
      end
      while ((busy || gate) && guard < 5000) begin
         if (gate) len++;
         @(negedge clk);
         guard++;
      end
   endtask

   task automatic single_gate(input int n, input bit mode, output int len);
      width = CW'(n);
      dual = mode;
      fork
         measure(len);
         begin align(); pulse(); end
      join
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int len;
      int exp;
      int spur;
      repeat (3) @(negedge clk);
      check(gate == 1'b0 && busy == 1'b0, "R10 reset state", {gate, busy}, 0);
      rst = 1'b0;
      repeat (3) @(negedge clk);

      // R1 / R4: single-edge sweep over every width
      for (int n = 0; n < (1 << CW); n++) begin
         single_gate(n, 1'b0, len);
         exp = STEP_S * ((n == 0) ? 1 : n);
         check(len == exp, (n == 0) ? "R4 zero width single" : "R1 single-edge length", len, exp);
      end

      // R2 / R4: dual-edge sweep
      for (int n = 0; n < (1 << CW); n++) begin
         single_gate(n, 1'b1, len);
         exp = STEP_D * ((n == 0) ? 1 : n);
         check(len == exp, (n == 0) ? "R4 zero width dual" : "R2 dual-edge length", len, exp);
      end

      // R3: width change after trigger is ignored
      width = CW'(3);
      dual = 1'b0;
      fork
         measure(len);
         begin align(); pulse(); width = CW'(20); end
      join
      check(len == 12, "R3 width captured at trigger", len, 12);

      // R5: long low level gives one gate only
      width = CW'(2);
      fork
         measure(len);
         begin align(); start_n = 1'b0; end
      join
      check(len == 8, "R5 held-low length", len, 8);
      spur = 0;
      for (int k = 0; k < 30; k++) begin
         @(negedge clk);
         if (busy || gate) spur++;
      end
      check(spur == 0, "R5 no retrigger while low", spur, 0);
      start_n = 1'b1;
      repeat (3) @(negedge clk);

      // R6: back-to-back gates without a gap
      width = CW'(2);
      single_gate(2, 1'b0, len);
      start_n = 1'b0;
      @(negedge clk);
      check(busy == 1'b1, "R6 busy after immediate restart", busy, 1);
      start_n = 1'b1;
      measure(len);
      check(len == 8, "R6 back-to-back length", len, 8);

      // R7: overlapping trigger merges (single-edge), gap 10 clocks
      width = CW'(6);
      dual = 1'b0;
      fork
         measure(len);
         begin align(); pulse(); repeat (9) @(negedge clk); pulse(); end
      join
      check(len == 10 + 24, "R7 merged single-edge", len, 34);

      // R7: overlapping trigger merges (dual-edge), gap 6 clocks
      dual = 1'b1;
      fork
         measure(len);
         begin align(); pulse(); repeat (5) @(negedge clk); pulse(); end
      join
      check(len == 6 + 12, "R7 merged dual-edge", len, 18);

      // R8: third trigger restarts the older channel
      dual = 1'b0;
      fork
         measure(len);
         begin
            align(); pulse();
            repeat (7) @(negedge clk); pulse();
            repeat (7) @(negedge clk); pulse();
         end
      join
      check(len == 16 + 24, "R8 triple trigger length", len, 40);

      // R9: busy high before the first step, gate low
      width = CW'(4);
      align();
      pulse();
      check(busy == 1'b1 && gate == 1'b0, "R9 busy before first step", {busy, gate}, 2);
      @(negedge clk);
      check(busy == 1'b1 && gate == 1'b1, "R9 busy with gate", {busy, gate}, 3);

      // R10: reset in the middle of a gate
      repeat (3) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check(gate == 1'b0 && busy == 1'b0, "R10 reset mid-gate", {gate, busy}, 0);
      rst = 1'b0;
      spur = 0;
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         if (busy || gate) spur++;
      end
      check(spur == 0, "R10 stays idle after reset", spur, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule